// File: doc/BRIEF.md
# ULPI Link Bus-Turnaround Controller

This block sits on the link side of the shared 8-bit data bus between a USB link and its transceiver. The transceiver owns the direction input. It raises that input when it wants the bus and lowers it when it gives the bus back. From this input the block builds the output enable for the link's bidirectional data pins. The enable drops in the same cycle that the direction input rises, through combinational logic only. It comes back one full clock after the direction input falls. Because of this, the two sides never drive the bus together.

The block also flags the turnaround cycles. It captures receive bytes only on cycles where the transceiver is really driving. While the link owns the bus, it drives either idle zeros or a transmit byte from a simple request and hold interface. If the transceiver takes the bus while a byte is still waiting, the byte is kept and an interrupted flag is raised so upper logic can retry.

A direction-tracking state machine has two states, SIDE_LINK and SIDE_PHY. It holds the direction input as sampled at the last edge. Combined with the live direction input, it gives four phases:
- PH_LINK_OWN: SIDE_LINK with the input low.
- PH_TO_PHY: SIDE_LINK with the input high. This is the turnaround towards the transceiver.
- PH_PHY_OWN: SIDE_PHY with the input high.
- PH_TO_LINK: SIDE_PHY with the input low. This is the turnaround back to the link.

The transmit holder has two states:
- TX_IDLE goes to TX_HELD when a request is taken.
- TX_HELD goes back to TX_IDLE when an accept strobe arrives while the link is driving.

Top module: `ulpi_turnaround_ctrl`

## Requirements
- R1: During and right after reset, with the direction input low, `bus_oe` is 1, `bus_out` is 8'h00, `turnaround` and `rx_valid` are 0, and `tx_busy`, `tx_interrupted` and `rx_data` are 0.
- R2: In a cycle where `ulpi_dir` is high but was low at the previous clock edge, `bus_oe` is 0 in that same cycle, with no register delay.
- R3: `bus_oe` is never 1 while `ulpi_dir` is 1. A transceiver enable registered from `ulpi_dir` is never active together with `bus_oe`.
- R4: In the first cycle after `ulpi_dir` falls, `bus_oe` stays 0. It is 1 from the next cycle on, as long as `ulpi_dir` stays low.
- R5: `turnaround` is 1 exactly in cycles where `ulpi_dir` differs from its value at the previous clock edge.
- R6: `rx_valid` is 1 exactly when `ulpi_dir` is high in this cycle and was high at the previous edge. `rx_data` loads `bus_in` at an edge only when `rx_valid` is 1, and otherwise holds its value.
- R7: When `bus_oe` is 1 and no byte is held (`tx_busy` = 0), `bus_out` is 8'h00. `bus_out` is 8'h00 whenever `bus_oe` is 0.
- R8: When `tx_busy` is 0, `tx_valid` = 1 at an edge loads `tx_byte` and sets `tx_busy`. The byte is driven on `bus_out` from the next cycle whenever `bus_oe` is 1. It stays driven until `tx_accept` is seen with `bus_oe` = 1, and `tx_valid` while busy is ignored.
- R9: `tx_accept` seen while `bus_oe` is 0 has no effect: the byte stays held and `tx_busy` stays 1.
- R10: If `ulpi_dir` rises while `tx_busy` is 1, `tx_interrupted` is 1 from the next cycle. The byte is kept and driven again once the link owns the bus. `tx_interrupted` clears when that byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ulpi_dir | input | 1 | Bus direction from the transceiver, high = transceiver drives |
| bus_in | input | 8 | Data bus as seen at the pins |
| bus_out | output | 8 | Data the link drives when enabled |
| bus_oe | output | 1 | Output enable for the link's data pins |
| turnaround | output | 1 | First cycle after a direction change |
| rx_valid | output | 1 | Bus carries a valid transceiver byte this cycle |
| rx_data | output | 8 | Last captured receive byte |
| tx_valid | input | 1 | Transmit byte offered |
| tx_byte | input | 8 | Transmit byte |
| tx_accept | input | 1 | Transceiver took the driven byte |
| tx_busy | output | 1 | A transmit byte is held |
| tx_interrupted | output | 1 | Held byte was cut off by a bus takeover |

## Verification
Two events can fall in the same cycle. The first is the transceiver taking the bus. The second is an accept strobe, or a new transmit request, for the byte the link is driving. The bench raises `ulpi_dir` in the very cycle that carries `tx_accept`, and also in a cycle that carries `tx_valid`. The required result is that the accept is dropped because the enable is already low, the byte stays held, and the interrupted flag sets. A behavioural reference model updated at every edge judges each outcome, along with a long stretch of mixed stimulus in which such collisions recur.

// File: rtl/ulpi_ta_pkg.sv
package ulpi_ta_pkg;
    typedef enum logic {
        SIDE_LINK = 1'b0,
        SIDE_PHY  = 1'b1
    } side_e;

    typedef enum logic [1:0] {
        PH_LINK_OWN = 2'd0,
        PH_TO_PHY   = 2'd1,
        PH_PHY_OWN  = 2'd2,
        PH_TO_LINK  = 2'd3
    } phase_e;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_HELD = 1'b1
    } txst_e;
endpackage

// File: rtl/ulpi_dir_tracker.sv
module ulpi_dir_tracker
    import ulpi_ta_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dir,
    output logic link_oe,
    output logic turnaround,
    output logic rx_valid,
    output logic dir_rise
);
    side_e  side_q;
    phase_e phase;

    // State register: which side drove at the last edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) side_q <= SIDE_LINK;
        else        side_q <= dir ? SIDE_PHY : SIDE_LINK;
    end

    // Phase decode from the live direction input
    always_comb begin
        unique case (side_q)
            SIDE_LINK: phase = dir ? PH_TO_PHY  : PH_LINK_OWN;
            SIDE_PHY:  phase = dir ? PH_PHY_OWN : PH_TO_LINK;
        endcase
    end

    // Outputs per phase
    always_comb begin
        link_oe    = 1'b0;
        turnaround = 1'b0;
        rx_valid   = 1'b0;
        dir_rise   = 1'b0;
        unique case (phase)
            PH_LINK_OWN: link_oe = 1'b1;
            PH_TO_PHY: begin
                turnaround = 1'b1;
                dir_rise   = 1'b1;
            end
            PH_PHY_OWN: rx_valid = 1'b1;
            PH_TO_LINK: turnaround = 1'b1;
        endcase
    end

    // R4
    oe_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dir) |-> !link_oe);

    // R5
    ta_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir != $past(dir)) |-> turnaround);

    // R6
    rx_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (dir && $past(dir)));
endmodule

// File: rtl/ulpi_tx_holder.sv
module ulpi_tx_holder
    import ulpi_ta_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tx_accept,
    input  logic              link_oe,
    input  logic              dir_rise,
    output logic [DATA_W-1:0] held_byte,
    output logic              busy,
    output logic              interrupted
);
    txst_e             st_q, st_d;
    logic [DATA_W-1:0] byte_q;
    logic              intr_q;
    logic              take, done;

    assign take = (st_q == TX_IDLE) && tx_valid;
    assign done = (st_q == TX_HELD) && tx_accept && link_oe;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_IDLE: if (tx_valid) st_d = TX_HELD;
            TX_HELD: if (tx_accept && link_oe) st_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= TX_IDLE;
            byte_q <= '0;
            intr_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (take) byte_q <= tx_byte;
            if (done) intr_q <= 1'b0;
            else if ((st_q == TX_HELD) && dir_rise) intr_q <= 1'b1;
        end
    end

    assign held_byte   = byte_q;
    assign busy        = (st_q == TX_HELD);
    assign interrupted = intr_q;

    // R8
    hold_until_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(tx_accept && link_oe)) |=> (busy && $stable(held_byte)));

    // R10
    intr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dir_rise) |=> interrupted);
endmodule

// File: rtl/ulpi_rx_capture.sv
module ulpi_rx_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] rx_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rx_data <= '0;
        else if (rx_valid) rx_data <= bus_in;
    end

    // R6
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(rx_data));
endmodule

// File: rtl/ulpi_turnaround_ctrl.sv
module ulpi_turnaround_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ulpi_dir,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              turnaround,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tx_accept,
    output logic              tx_busy,
    output logic              tx_interrupted
);
    localparam logic [DATA_W-1:0] IDLE_WORD = '0;

    logic              link_oe, dir_rise;
    logic [DATA_W-1:0] held_byte;

    ulpi_dir_tracker u_dir (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir        (ulpi_dir),
        .link_oe    (link_oe),
        .turnaround (turnaround),
        .rx_valid   (rx_valid),
        .dir_rise   (dir_rise)
    );

    ulpi_tx_holder #(.DATA_W(DATA_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_valid    (tx_valid),
        .tx_byte     (tx_byte),
        .tx_accept   (tx_accept),
        .link_oe     (link_oe),
        .dir_rise    (dir_rise),
        .held_byte   (held_byte),
        .busy        (tx_busy),
        .interrupted (tx_interrupted)
    );

    ulpi_rx_capture #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .bus_in   (bus_in),
        .rx_data  (rx_data)
    );

    assign bus_oe  = link_oe;
    assign bus_out = (link_oe && tx_busy) ? held_byte : IDLE_WORD;

    // R3
    no_drive_while_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ulpi_dir |-> !bus_oe);

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_oe && tx_busy) |-> (bus_out == IDLE_WORD));
endmodule

// File: tb/ulpi_turnaround_ctrl_tb.sv
module ulpi_turnaround_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ulpi_dir = 1'b0;
    logic [7:0] bus_in = '0;
    logic [7:0] bus_out;
    logic       bus_oe, turnaround, rx_valid;
    logic [7:0] rx_data;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       tx_accept = 1'b0;
    logic       tx_busy, tx_interrupted;

    int n_checks = 0;
    int n_fail = 0;

    // reference model state
    int m_dirq = 0, m_pend = 0, m_byte = 0, m_intr = 0, m_rx = 0;

    always #5 clk = ~clk;

    ulpi_turnaround_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ulpi_dir(ulpi_dir), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .turnaround(turnaround),
        .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .tx_accept(tx_accept), .tx_busy(tx_busy),
        .tx_interrupted(tx_interrupted)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, compare after settling, update model at posedge
    task automatic step(input bit d, input int din, input bit tv, input int tb, input bit ta);
        int e_oe, e_ta, e_rxv, e_out, phy_oe;
        @(negedge clk);
        ulpi_dir = d; bus_in = din[7:0]; tx_valid = tv; tx_byte = tb[7:0]; tx_accept = ta;
        #1;
        e_oe  = (!d && m_dirq == 0) ? 1 : 0;
        e_ta  = (int'(d) != m_dirq) ? 1 : 0;
        e_rxv = (d && m_dirq == 1) ? 1 : 0;
        e_out = (e_oe == 1 && m_pend == 1) ? m_byte : 0;
        phy_oe = m_dirq;   // transceiver enable registered from direction
        chk(int'(bus_oe), e_oe, "R2 R4 bus_oe");
        chk(int'(bus_oe && phy_oe == 1), 0, "R3 contention");
        chk(int'(bus_oe && d), 0, "R3 oe_with_dir");
        chk(int'(turnaround), e_ta, "R5 turnaround");
        chk(int'(rx_valid), e_rxv, "R6 rx_valid");
        chk(int'(rx_data), m_rx, "R6 rx_data");
        chk(int'(bus_out), e_out, "R7 R8 R10 bus_out");
        chk(int'(tx_busy), m_pend, "R8 R9 tx_busy");
        chk(int'(tx_interrupted), m_intr, "R10 tx_interrupted");
        @(posedge clk);
        if (e_rxv == 1) m_rx = din & 8'hff;
        if (m_pend == 0) begin
            if (tv) begin m_pend = 1; m_byte = tb & 8'hff; end
        end else begin
            if (ta && e_oe == 1) begin m_pend = 0; m_intr = 0; end
            else if (d && m_dirq == 0) m_intr = 1;
        end
        m_dirq = int'(d);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(int'(bus_oe), 1, "R1 bus_oe");
        chk(int'(bus_out), 0, "R1 bus_out");
        chk(int'(tx_busy), 0, "R1 tx_busy");
        chk(int'(tx_interrupted), 0, "R1 tx_interrupted");
        chk(int'(rx_data), 0, "R1 rx_data");
        chk(int'(turnaround), 0, "R1 turnaround");
        @(negedge clk); rst_n = 1'b1;
        // R7 idle
        step(0, 8'h55, 0, 0, 0);
        step(0, 8'h66, 0, 0, 0);
        // R8 load, hold, ignore second request
        step(0, 0, 1, 8'hA5, 0);
        step(0, 0, 1, 8'h3C, 0);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0);
        // R10 direction rises with accept in the same cycle
        step(0, 0, 1, 8'h81, 0);
        step(1, 8'hEE, 0, 0, 1);
        step(1, 8'h12, 0, 0, 0);
        step(1, 8'h34, 0, 0, 1);
        step(0, 8'h99, 0, 0, 1);   // R9 accept during holdoff ignored
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1);       // R10 accept clears flag
        step(0, 0, 0, 0, 0);
        // load in the cycle direction rises
        step(1, 8'h77, 1, 8'hC3, 0);
        step(1, 8'h42, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1);
        // single-cycle direction pulse
        step(1, 8'hAB, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        // mixed stimulus
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 3) == 0, $urandom & 8'hff, ($urandom % 4) == 0,
                 $urandom & 8'hff, ($urandom % 3) == 0);
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule